// File: doc/BRIEF.md
# Debug Reset and Power-Down Control Register

This block is a single 32-bit control register on a debug register port. Through it an external debugger can do three things. It can ask an external reset controller to reset the core, using a timed request pulse. It can keep the core's non-debug logic in reset once a warm reset ends, so that debug state can be restored before the core runs again. It can ask the system power controller to emulate power-down and keep the core powered.

The block has two reset inputs. The power-on reset clears every flop in the block. The warm reset input only feeds the hold logic and leaves the register contents alone. A sticky hold flag is set by software and is cleared only by software or by power-on reset. When that flag is set, a warm reset is stretched until the flag is cleared.

The register port has no data stream, so there is no valid/ready handshake. A write takes effect on the clock edge where the one-cycle write strobe is high. The read bus shows the register contents combinationally, so there is no back-pressure.

Top module: `dbg_rst_pwr_ctl`

## Requirements
- R1: Bits [31:3] of the read bus are always 0, and writing any value to them changes no output.
- R2: Bit 0 (no-power-down) is loaded on every write and drives `no_pwrdn_o` directly. It reads back at bit 0 and is 0 after power-on reset.
- R3: A write with bit 1 set drives `rst_req_o` high for exactly four clock cycles, starting in the cycle after the write edge.
- R4: Bit 1 (force reset) always reads as 0. A write with bit 1 clear does not start, stop or lengthen a request pulse.
- R5: A write with bit 1 set while a pulse is running restarts the pulse with a full four cycles.
- R6: Bit 2 (hold) is loaded on every write, reads back at bit 2, and is 0 after power-on reset.
- R7: Bits 0 and 2 keep their values while warm reset is asserted and after it ends.
- R8: `core_hold_rst_o` is high in every cycle where `warm_rst_n` is low.
- R9: If bit 2 is 1 when a warm reset occurs, `core_hold_rst_o` stays high after `warm_rst_n` returns high. It falls in the cycle right after the write edge that clears bit 2.
- R10: If bit 2 is 0, `core_hold_rst_o` follows the warm reset and falls as soon as `warm_rst_n` returns high.
- R11: Power-on reset clears bit 2 and the warm-reset memory. After power-up, therefore, `core_hold_rst_o` is low while `warm_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| warm_rst_n | input | 1 | Warm reset of the core, active low, sampled |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data: {29'b0, hold, 1'b0, no-power-down} |
| rst_req_o | output | 1 | Reset request to the external reset controller |
| core_hold_rst_o | output | 1 | Reset to the core's non-debug logic |
| no_pwrdn_o | output | 1 | Emulate-power-down request to the power controller |

## Verification
The request pulse is driven three ways, and each shows a different fault:
- A lone start, followed by a write with bit 1 clear, catches a pulse of the wrong length and a zero-write that retriggers the pulse.
- A second start partway through the pulse catches a restart that is ignored or that adds to the remaining count.
- A write of all ones and a write of only the reserved bits catch bits that leak through or are decoded at the wrong position.

The hold path is tried in three situations: a warm reset with the hold flag set, a warm reset with the flag clear, and a power-on reset taken while the flag was set. These tell apart a hold flag that warm reset clears, a release that comes one cycle late, and a flag that survives power-on reset.

// File: rtl/dbg_rst_pkg.sv
package dbg_rst_pkg;
  localparam int REG_W      = 32;
  localparam int USED_BITS  = 3;
  // Bit positions are decoded by software and the debugger.
  localparam int NOPWR_BIT  = 0;
  localparam int FORCE_BIT  = 1;
  localparam int HOLD_BIT   = 2;
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_rst_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 wr_en,
  input  logic [USED_BITS-1:0] wr_bits,
  output logic                 nopwr_q,
  output logic                 hold_q,
  output logic                 force_start,
  output logic [REG_W-1:0]     rd_data
);
  // Power-on domain only: warm reset does not reach these flops.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      nopwr_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (wr_en) begin
      nopwr_q <= wr_bits[NOPWR_BIT];
      hold_q  <= wr_bits[HOLD_BIT];
    end
  end

  assign force_start = wr_en & wr_bits[FORCE_BIT];

  always_comb begin
    rd_data            = '0;
    rd_data[NOPWR_BIT] = nopwr_q;
    rd_data[HOLD_BIT]  = hold_q;
  end

  // R7: without a write, the stored bits never change (warm reset included)
  p_bits_persist_r7: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable({nopwr_q, hold_q}));

  // R6: a write loads the hold flag from the write data
  p_hold_load_r6: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> (hold_q == $past(wr_bits[HOLD_BIT])));
endmodule

// File: rtl/dbg_rst_pulse.sv
module dbg_rst_pulse #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  output logic req_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                remain_q <= '0;
    else if (start)            remain_q <= LOAD;
    else if (remain_q != '0)   remain_q <= remain_q - CNT_W'(1);
  end

  assign req_o = (remain_q != '0);

  // R3: a start is always followed by an asserted request
  p_start_req_r3: assert property (@(posedge clk) disable iff (!por_n)
    start |=> req_o);

  // R5: a start during a running pulse reloads the full count
  p_restart_full_r5: assert property (@(posedge clk) disable iff (!por_n)
    (start && req_o) |=> (remain_q == LOAD));
endmodule

// File: rtl/dbg_hold_gate.sv
module dbg_hold_gate (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic hold_en,
  output logic hold_rst_o
);
  logic warm_seen_q;

  // Set by a warm reset, dropped as soon as the hold flag is clear.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           warm_seen_q <= 1'b0;
    else if (!warm_rst_n) warm_seen_q <= 1'b1;
    else if (!hold_en)    warm_seen_q <= 1'b0;
  end

  assign hold_rst_o = !warm_rst_n || (hold_en && warm_seen_q);

  // R8: warm reset always reaches the core
  p_warm_forces_r8: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |-> hold_rst_o);

  // R9: with the flag set, the end of warm reset does not release the core
  p_stretch_r9: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(warm_rst_n) && hold_en) |-> hold_rst_o);

  // R9: clearing the flag outside warm reset releases the core at once
  p_release_r9: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(hold_en) && warm_rst_n) |-> !hold_rst_o);

  // R10: with the flag clear, the core leaves reset together with warm reset
  p_follow_r10: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst_n && !hold_en) |-> !hold_rst_o);
endmodule

// File: rtl/dbg_rst_pwr_ctl.sv
module dbg_rst_pwr_ctl
  import dbg_rst_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             warm_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             rst_req_o,
  output logic             core_hold_rst_o,
  output logic             no_pwrdn_o
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PULSE_CYCLES);

  logic nopwr_q;
  logic hold_q;
  logic force_start;

  dbg_ctl_regs u_regs (
    .clk         (clk),
    .por_n       (por_n),
    .wr_en       (wr_en),
    .wr_bits     (wr_data[USED_BITS-1:0]),
    .nopwr_q     (nopwr_q),
    .hold_q      (hold_q),
    .force_start (force_start),
    .rd_data     (rd_data)
  );

  dbg_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk   (clk),
    .por_n (por_n),
    .start (force_start),
    .req_o (rst_req_o)
  );

  dbg_hold_gate u_hold (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .hold_en    (hold_q),
    .hold_rst_o (core_hold_rst_o)
  );

  assign no_pwrdn_o = nopwr_q;

  // Checker state: length of the current request run, counted at the ports.
  logic [RUN_W-1:0] run_len_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                              run_len_q <= '0;
    else if (wr_en && wr_data[FORCE_BIT])    run_len_q <= RUN_W'(1);
    else if (rst_req_o && run_len_q != '1)   run_len_q <= run_len_q + RUN_W'(1);
    else if (!rst_req_o)                     run_len_q <= '0;
  end

  // R3: a run never exceeds the pulse length and ends exactly at it
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_o |-> (run_len_q >= RUN_W'(1) && run_len_q <= RUN_MAX));
  p_run_end_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_req_o) |-> ($past(run_len_q) == RUN_MAX));

  // R1: reserved write bits never show up on the read bus
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && |wr_data[REG_W-1:USED_BITS]) |=> (rd_data[REG_W-1:USED_BITS] == '0));

  // R2: the power-down request follows the last written bit 0
  p_nopwr_load_r2: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> (no_pwrdn_o == $past(wr_data[NOPWR_BIT])));

  // R4: a write without bit 1 never starts a request from idle
  p_zero_noop_r4: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !wr_data[FORCE_BIT] && !rst_req_o) |=> !rst_req_o);

  // R4: the force bit never reads back as set
  p_force_reads0_r4: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data[FORCE_BIT]) |=> !rd_data[FORCE_BIT]);
endmodule

// File: tb/dbg_rst_pwr_ctl_tb_top.sv
module dbg_rst_pwr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rst_req_o;
  logic        core_hold_rst_o;
  logic        no_pwrdn_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dbg_rst_pwr_ctl dut_i (
    .clk             (clk),
    .por_n           (por_n),
    .warm_rst_n      (warm_rst_n),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .rd_data         (rd_data),
    .rst_req_o       (rst_req_o),
    .core_hold_rst_o (core_hold_rst_o),
    .no_pwrdn_o      (no_pwrdn_o)
  );

  typedef struct {
    string       tag;
    logic        req;
    logic        hold;
    logic        np;
    logic [31:0] rd;
  } exp_t;

  exp_t sb_q[$];

  // Driver: apply inputs at the falling edge, push what must be seen after the next rising edge.
  task automatic cyc(input logic w, input logic [31:0] d, input logic warm,
                     input logic e_req, input logic e_hold, input logic e_np,
                     input logic [31:0] e_rd, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = w; wr_data = d; warm_rst_n = warm;
    it.tag = tag; it.req = e_req; it.hold = e_hold; it.np = e_np; it.rd = e_rd;
    sb_q.push_back(it);
  endtask

  task automatic power_on_reset();
    @(negedge clk);
    por_n = 1'b0; wr_en = 1'b0; wr_data = '0; warm_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  // Monitor: pop and compare shortly after each rising edge.
  always begin
    @(posedge clk);
    #2;
    while (sb_q.size() > 0) begin
      exp_t it;
      bit bad;
      it = sb_q.pop_front();
      bad = 0;
      compared++;
      if (rst_req_o !== it.req) begin
        $display("FAIL %s rst_req_o actual=%b expected=%b", it.tag, rst_req_o, it.req); bad = 1;
      end
      if (core_hold_rst_o !== it.hold) begin
        $display("FAIL %s core_hold_rst_o actual=%b expected=%b", it.tag, core_hold_rst_o, it.hold); bad = 1;
      end
      if (no_pwrdn_o !== it.np) begin
        $display("FAIL %s no_pwrdn_o actual=%b expected=%b", it.tag, no_pwrdn_o, it.np); bad = 1;
      end
      if (rd_data !== it.rd) begin
        $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd); bad = 1;
      end
      if (bad) mismatched++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // Reset state: R6, R2, R11
    cyc(0, 32'h0, 1, 0, 0, 0, 32'h0, "R6 reset state");
    // All ones: R1 reserved dropped, R4 force reads 0, R3 pulse starts
    cyc(1, 32'hFFFF_FFFF, 1, 1, 0, 1, 32'h5, "R1 write all ones");
    // Zero write mid-pulse: R4 no effect on pulse
    cyc(1, 32'h0, 1, 1, 0, 0, 32'h0, "R4 zero write");
    cyc(0, 32'h0, 1, 1, 0, 0, 32'h0, "R3 pulse cycle 3");
    cyc(0, 32'h0, 1, 1, 0, 0, 32'h0, "R3 pulse cycle 4");
    cyc(0, 32'h0, 1, 0, 0, 0, 32'h0, "R3 pulse ended");
    cyc(0, 32'h0, 1, 0, 0, 0, 32'h0, "R3 idle");
    // Reserved only: R1
    cyc(1, 32'hFFFF_FFF8, 1, 0, 0, 0, 32'h0, "R1 reserved only");
    // Restart: R5 (6 cycles high total)
    cyc(1, 32'h2, 1, 1, 0, 0, 32'h0, "R5 first start");
    cyc(0, 32'h0, 1, 1, 0, 0, 32'h0, "R5 run 2");
    cyc(1, 32'h2, 1, 1, 0, 0, 32'h0, "R5 restart");
    cyc(0, 32'h0, 1, 1, 0, 0, 32'h0, "R5 after restart 2");
    cyc(0, 32'h0, 1, 1, 0, 0, 32'h0, "R5 after restart 3");
    cyc(0, 32'h0, 1, 1, 0, 0, 32'h0, "R5 after restart 4");
    cyc(0, 32'h0, 1, 0, 0, 0, 32'h0, "R5 restarted pulse ended");
    // No-power-down bit: R2
    cyc(1, 32'h1, 1, 0, 0, 1, 32'h1, "R2 set");
    cyc(1, 32'h0, 1, 0, 0, 0, 32'h0, "R2 clear");
    // Hold across warm reset: R7, R8, R9
    cyc(1, 32'h5, 1, 0, 0, 1, 32'h5, "R6 set hold");
    cyc(0, 32'h0, 0, 0, 1, 1, 32'h5, "R8 warm active");
    cyc(0, 32'h0, 0, 0, 1, 1, 32'h5, "R7 warm persist");
    cyc(0, 32'h0, 1, 0, 1, 1, 32'h5, "R9 stretched");
    cyc(0, 32'h0, 1, 0, 1, 1, 32'h5, "R9 still held");
    cyc(1, 32'h1, 1, 0, 0, 1, 32'h1, "R9 release");
    cyc(0, 32'h0, 1, 0, 0, 1, 32'h1, "R9 stays released");
    // Hold clear: R10
    cyc(0, 32'h0, 0, 0, 1, 1, 32'h1, "R10 warm active");
    cyc(0, 32'h0, 1, 0, 0, 1, 32'h1, "R10 follows warm");
    // Power-on reset clears hold: R11
    cyc(1, 32'h5, 1, 0, 0, 1, 32'h5, "R11 arm hold");
    cyc(0, 32'h0, 0, 0, 1, 1, 32'h5, "R11 warm with hold");
    power_on_reset();
    cyc(0, 32'h0, 1, 0, 0, 0, 32'h0, "R11 after power-on");
    cyc(0, 32'h0, 1, 0, 0, 0, 32'h0, "R11 stays released");

    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        mismatched++;
        compared++;
      end
    join_any
    if (sb_q.size() != 0) begin
      $display("FAIL scoreboard not drained actual=%0d expected=0", sb_q.size());
      mismatched++;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule